// File: doc/BRIEF.md
# Lockable Fan-Control Register Bank

This block holds the software-visible settings of a fan-control and monitoring controller: one duty-cycle ceiling per fan channel and a single configuration byte. It has a simple synchronous byte port. A write strobe stores the write data at the given address on the next clock edge. A read strobe captures the addressed byte into a read-data register, which holds that value until the next read.

From these registers the block drives the control inputs of the PWM generators: a duty ceiling per channel, a force-full-speed flag and a monitoring-enable flag. While monitoring is off, every ceiling is driven to full scale so that the fans give thermal protection. The programmed ceilings are kept and return once monitoring is enabled again.

A lock bit can be written only to 1. Once set, it freezes the duty ceilings and the protected configuration bits until the next reset. The start bit and the force-full-speed bit stay writable while locked. A ready bit, which software cannot write, is set by hardware a fixed number of cycles after reset is released.

Top module: `fanreg_bank`

## Requirements
- R1: Channel k has its duty ceiling at byte address 0x38+k (k = 0 to NUM_CH-1). Each ceiling resets to 0xFF (full scale). While unlocked, a write stores the byte, and it reads back as written.
- R2: The configuration byte is at address 0x40. Its bit positions are: 0 start, 1 lock, 2 ready, 3 force full speed, 4 power-measure flag, 5 spin-up disable, 6 bus-timeout disable, 7 reserved. Once ready, it reads 0x04 after reset.
- R3: A write with bit 1 set to 1 sets the lock. No write clears the lock; only reset clears it.
- R4: While the lock is set, writes to the duty ceilings and to configuration bits 4, 5 and 6 have no effect. A write in the same cycle that sets the lock still updates bits 4 to 6.
- R5: Configuration bits 0 and 3 accept writes whether or not the lock is set.
- R6: The ready bit (bit 2) reads 0 until READY_DELAY rising edges after reset release, then reads 1 until reset. Writes do not change it.
- R7: While the start bit is 0, every duty_max_o byte is 0xFF. The programmed ceilings are kept.
- R8: While the start bit is 1, duty_max_o byte k (bits 8k+7 to 8k) equals channel k's ceiling. full_speed_o equals configuration bit 3, and mon_en_o equals bit 0.
- R9: Configuration bit 7 ignores writes and always reads 0.
- R10: rdata_o updates at the rising edge where rd_en_i is high and holds otherwise. A read of any address other than 0x38 to 0x38+NUM_CH-1 and 0x40 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| duty_max_o | output | 8*NUM_CH | Effective duty ceiling per channel, channel 0 in the low byte |
| full_speed_o | output | 1 | Force-full-speed request |
| mon_en_o | output | 1 | Monitoring enable |

## Verification
A write becomes visible on duty_max_o, full_speed_o and mon_en_o right after the rising edge that samples the strobe, because those outputs are combinational functions of the registers. Read data becomes visible one edge after the read strobe. The ready bit rises READY_DELAY edges after reset release. The bench drives inputs on falling edges and advances its reference model at each rising edge: the model first reads, then applies writes, then advances the ready counter. On every falling edge it compares all outputs with the model. Directed reads then check each locked, unlocked and reserved case against literal expected bytes one edge after the strobe.

// File: rtl/fanreg_pkg.sv
package fanreg_pkg;

    localparam int BYTE_W = 8;

    // Configuration byte, bit 7 first.
    typedef struct packed {
        logic rsvd;
        logic no_timeout;
        logic no_spinup;
        logic pwr_meas;
        logic full_speed;
        logic ready;
        logic lock;
        logic start;
    } cfg_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    function automatic logic [BYTE_W-1:0] cfg_to_byte(cfg_t c);
        logic [BYTE_W-1:0] b;
        b    = c;
        b[7] = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/fanreg_ready_timer.sv
module fanreg_ready_timer #(
    parameter int READY_DELAY = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic ready_o
);
    localparam int CW = (READY_DELAY < 1) ? 1 : $clog2(READY_DELAY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(READY_DELAY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            ready_o <= (READY_DELAY == 0);
        end else if (!ready_o) begin
            cnt_q   <= cnt_q + 1'b1;
            ready_o <= ((cnt_q + 1'b1) == LIMIT);
        end
    end
endmodule

// File: rtl/fanreg_duty_bank.sv
module fanreg_duty_bank
    import fanreg_pkg::*;
#(
    parameter int              NUM_CH    = 3,
    parameter logic [BYTE_W-1:0] DUTY_BASE = 8'h38
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  bus_req_t                 req_i,
    input  logic                     lock_i,
    output logic [NUM_CH*BYTE_W-1:0] duty_q_o
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [BYTE_W-1:0] CH_ADDR = BYTE_W'(DUTY_BASE + ch);
        logic hit;
        assign hit = req_i.wr && (req_i.addr == CH_ADDR) && !lock_i;
        always_ff @(posedge clk_i) begin
            if (rst_i)
                duty_q_o[ch*BYTE_W +: BYTE_W] <= '1;
            else if (hit)
                duty_q_o[ch*BYTE_W +: BYTE_W] <= req_i.data;
        end
    end
endmodule

// File: rtl/fanreg_cfg_reg.sv
module fanreg_cfg_reg
    import fanreg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CFG_ADDR = 8'h40
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  bus_req_t req_i,
    input  logic     ready_i,
    output cfg_t     cfg_o
);
    logic sel;
    logic start_q, lock_q, full_q, pwr_q, nospin_q, notmo_q;
    logic unused_bits;

    assign sel         = req_i.wr && (req_i.addr == CFG_ADDR);
    assign unused_bits = ^{req_i.data[7], req_i.data[2], req_i.rd};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q  <= 1'b0;
            lock_q   <= 1'b0;
            full_q   <= 1'b0;
            pwr_q    <= 1'b0;
            nospin_q <= 1'b0;
            notmo_q  <= 1'b0;
        end else if (sel) begin
            start_q <= req_i.data[0];
            full_q  <= req_i.data[3];
            lock_q  <= lock_q | req_i.data[1];
            if (!lock_q) begin
                pwr_q    <= req_i.data[4];
                nospin_q <= req_i.data[5];
                notmo_q  <= req_i.data[6];
            end
        end
    end

    always_comb begin
        cfg_o            = '0;
        cfg_o.start      = start_q;
        cfg_o.lock       = lock_q;
        cfg_o.ready      = ready_i;
        cfg_o.full_speed = full_q;
        cfg_o.pwr_meas   = pwr_q;
        cfg_o.no_spinup  = nospin_q;
        cfg_o.no_timeout = notmo_q;
    end
endmodule

// File: rtl/fanreg_bank.sv
module fanreg_bank
    import fanreg_pkg::*;
#(
    parameter int                NUM_CH      = 3,
    parameter logic [BYTE_W-1:0] DUTY_BASE   = 8'h38,
    parameter logic [BYTE_W-1:0] CFG_ADDR    = 8'h40,
    parameter int                READY_DELAY = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     wr_en_i,
    input  logic                     rd_en_i,
    input  logic [BYTE_W-1:0]        addr_i,
    input  logic [BYTE_W-1:0]        wdata_i,
    output logic [BYTE_W-1:0]        rdata_o,
    output logic [NUM_CH*BYTE_W-1:0] duty_max_o,
    output logic                     full_speed_o,
    output logic                     mon_en_o
);
    bus_req_t                 req;
    cfg_t                     cfg_w;
    logic                     ready_w;
    logic [NUM_CH*BYTE_W-1:0] duty_q;
    logic [BYTE_W-1:0]        rd_next;

    assign req = '{wr: wr_en_i, rd: rd_en_i, addr: addr_i, data: wdata_i};

    fanreg_ready_timer #(.READY_DELAY(READY_DELAY)) ready_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .ready_o(ready_w)
    );

    fanreg_cfg_reg #(.CFG_ADDR(CFG_ADDR)) cfg_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (req),
        .ready_i(ready_w),
        .cfg_o  (cfg_w)
    );

    fanreg_duty_bank #(.NUM_CH(NUM_CH), .DUTY_BASE(DUTY_BASE)) duty_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .req_i   (req),
        .lock_i  (cfg_w.lock),
        .duty_q_o(duty_q)
    );

    always_comb begin
        rd_next = '0;
        if (req.addr == CFG_ADDR)
            rd_next = cfg_to_byte(cfg_w);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (req.addr == BYTE_W'(DUTY_BASE + ch))
                rd_next = duty_q[ch*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)
            rdata_o <= '0;
        else if (req.rd)
            rdata_o <= rd_next;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
        assign duty_max_o[ch*BYTE_W +: BYTE_W] =
            cfg_w.start ? duty_q[ch*BYTE_W +: BYTE_W] : {BYTE_W{1'b1}};
    end

    assign full_speed_o = cfg_w.full_speed;
    assign mon_en_o     = cfg_w.start;
endmodule

// File: rtl/fanreg_bank_chk.sv
module fanreg_bank_chk #(
    parameter int       NUM_CH    = 3,
    parameter logic [7:0] DUTY_BASE = 8'h38,
    parameter logic [7:0] CFG_ADDR  = 8'h40
) (
    input logic                clk,
    input logic                rst,
    input logic                lock,
    input logic                ready,
    input logic                mon_en,
    input logic                rd_en,
    input logic [7:0]          addr,
    input logic [7:0]          rdata,
    input logic [NUM_CH*8-1:0] duty_q,
    input logic [NUM_CH*8-1:0] duty_max
);
    logic mapped;
    assign mapped = (addr == CFG_ADDR) ||
                    ((addr >= DUTY_BASE) && (addr < 8'(DUTY_BASE + NUM_CH)));

    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    assert_duty_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(duty_q));

    assert_ready_holds_R6: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_idle_full_scale_R7: assert property (@(posedge clk) disable iff (rst)
        !mon_en |-> (duty_max == '1));

    assert_enabled_passes_ceiling_R8: assert property (@(posedge clk) disable iff (rst)
        mon_en |-> (duty_max == duty_q));

    assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !mapped) |=> (rdata == 8'h00));
endmodule

bind fanreg_bank fanreg_bank_chk #(
    .NUM_CH(NUM_CH), .DUTY_BASE(DUTY_BASE), .CFG_ADDR(CFG_ADDR)
) chk_i (
    .clk     (clk_i),
    .rst     (rst_i),
    .lock    (cfg_w.lock),
    .ready   (ready_w),
    .mon_en  (mon_en_o),
    .rd_en   (rd_en_i),
    .addr    (addr_i),
    .rdata   (rdata_o),
    .duty_q  (duty_q),
    .duty_max(duty_max_o)
);

// File: tb/fanreg_bank_tb_top.sv
`timescale 1ns/1ps
module fanreg_bank_tb_top;
    localparam int NCH = 3;
    localparam int DLY = 8;

    logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
    logic [7:0] addr = 0, wdata = 0;
    logic [7:0] rdata;
    logic [NCH*8-1:0] duty_max;
    logic full_speed, mon_en;

    int total = 0, fails = 0;
    bit done = 0, armed = 0;

    always #2.5 clk = ~clk;

    fanreg_bank #(.NUM_CH(NCH), .READY_DELAY(DLY)) dut_i (
        .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .duty_max_o(duty_max), .full_speed_o(full_speed), .mon_en_o(mon_en)
    );

    // behavioural reference model
    int m_duty[NCH];
    bit m_start, m_lock, m_ff, m_pm, m_ns, m_nt, m_rdy;
    int m_cnt;
    logic [7:0] m_rd;

    function automatic logic [7:0] m_cfg();
        return {1'b0, m_nt, m_ns, m_pm, m_ff, m_rdy, m_lock, m_start};
    endfunction

    function automatic logic [7:0] m_read(logic [7:0] a);
        if (a == 8'h40) return m_cfg();
        if (a >= 8'h38 && a < 8'h38 + NCH) return 8'(m_duty[a - 8'h38]);
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_duty[i]) m_duty[i] = 255;
            {m_start, m_lock, m_ff, m_pm, m_ns, m_nt} = '0;
            m_rdy = (DLY == 0);
            m_cnt = 0;
            m_rd  = 0;
        end else begin
            if (rd_en) m_rd = m_read(addr);
            if (wr_en) begin
                if (addr == 8'h40) begin
                    m_start = wdata[0];
                    m_ff    = wdata[3];
                    if (!m_lock) {m_nt, m_ns, m_pm} = wdata[6:4];
                    m_lock = m_lock | wdata[1];
                end else if (addr >= 8'h38 && addr < 8'h38 + NCH && !m_lock) begin
                    m_duty[addr - 8'h38] = wdata;
                end
            end
            if (!m_rdy) begin
                m_cnt++;
                if (m_cnt == DLY) m_rdy = 1;
            end
        end
        armed = 1;
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !rst && !done) begin
            for (int k = 0; k < NCH; k++) begin
                logic [7:0] e;
                e = m_start ? 8'(m_duty[k]) : 8'hFF;
                check(duty_max[k*8 +: 8] == e, m_start ? "R8 duty" : "R7 duty",
                      32'(duty_max[k*8 +: 8]), 32'(e));
            end
            check(full_speed == m_ff, "R8 full_speed", 32'(full_speed), 32'(m_ff));
            check(mon_en == m_start, "R8 mon_en", 32'(mon_en), 32'(m_start));
            check(rdata == m_rd, "R10 rdata", 32'(rdata), 32'(m_rd));
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0;
        check(rdata == exp, tag, 32'(rdata), 32'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        rd_chk(8'h40, 8'h00, "R6 not ready yet");
        repeat (10) @(negedge clk);
        rd_chk(8'h40, 8'h04, "R2 reset value");
        rd_chk(8'h38, 8'hFF, "R1 ch0 reset");
        rd_chk(8'h39, 8'hFF, "R1 ch1 reset");
        rd_chk(8'h3A, 8'hFF, "R1 ch2 reset");
        wr(8'h40, 8'h04);
        rd_chk(8'h40, 8'h04, "R6 ready not writable");
        wr(8'h38, 8'h40); wr(8'h39, 8'h80); wr(8'h3A, 8'h11);
        rd_chk(8'h38, 8'h40, "R1 ch0 write");
        rd_chk(8'h39, 8'h80, "R1 ch1 write");
        rd_chk(8'h3A, 8'h11, "R1 ch2 write");
        check(duty_max == 24'hFFFFFF, "R7 start off", duty_max, 24'hFFFFFF);
        wr(8'h40, 8'h01);
        check(duty_max == 24'h118040, "R8 start on", duty_max, 24'h118040);
        wr(8'h40, 8'hF9);
        rd_chk(8'h40, 8'h7D, "R9 reserved bit reads 0");
        check(full_speed == 1'b1, "R8 force flag", 32'(full_speed), 1);
        wr(8'h40, 8'h01);
        rd_chk(8'h40, 8'h05, "R2 bits cleared");
        rd_chk(8'h37, 8'h00, "R10 below range");
        rd_chk(8'h3B, 8'h00, "R10 above range");
        rd_chk(8'h41, 8'h00, "R10 past config");
        wr(8'h40, 8'h13);
        rd_chk(8'h40, 8'h17, "R4 same-cycle lock write");
        wr(8'h38, 8'h22);
        rd_chk(8'h38, 8'h40, "R4 duty frozen");
        wr(8'h40, 8'h60);
        rd_chk(8'h40, 8'h16, "R3 lock stays, R4 bits frozen, R5 start cleared");
        check(duty_max == 24'hFFFFFF, "R7 locked start off", duty_max, 24'hFFFFFF);
        wr(8'h40, 8'h09);
        rd_chk(8'h40, 8'h1F, "R5 start and force writable");
        check(duty_max == 24'h118040, "R7 ceilings preserved", duty_max, 24'h118040);
        do_reset();
        repeat (12) @(negedge clk);
        rd_chk(8'h40, 8'h04, "R3 reset clears lock");
        wr(8'h38, 8'h55);
        rd_chk(8'h38, 8'h55, "R3 writable after reset");
        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule